// File: doc/BRIEF.md
# Time-Varying FIR Filter with Stepwise Coefficient Interpolation

This block is a direct-form FIR filter for a channel emulator. It convolves a stream of 12-bit input samples with a set of tap weights and emits one 14-bit result for each accepted sample. There is no block buffering, so the only latency is one output register. The tap weights change over time while the filter keeps running. A small register file holds one coefficient bank for each fundamental channel state and one per-tap increment set for each state. Each pulse on the step strobe adds the current state's increment set to every active tap, so the response moves through interpolated states toward the next fundamental state.

After NSTEPS-1 increments (49 with the defaults), the next step does not add. It copies the next fundamental bank verbatim into the active taps, which discards any rounding drift, and it switches to that state's increment set. The state after the last one is state 0. Coefficients are usually stored already shifted toward tap 0 to cut latency, but the hardware treats them as plain numbers.

The controller is a small state machine with these states:
- PH_IDLE: after reset. The taps are zero and steps are ignored.
- PH_RAMP: each step adds the increment set.
- PH_LAST: the increment count is complete, so the next step reloads.

The transitions are:
- PH_IDLE→PH_RAMP on a restart.
- PH_RAMP→PH_RAMP on a step that is not the final increment.
- PH_RAMP→PH_LAST on the final increment.
- PH_LAST→PH_RAMP on a step, which reloads from the next bank.
- Any state→PH_RAMP on a restart, which loads bank 0.

Top module: `tvfir_interp`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high, and low otherwise. The result combines the sample just accepted with the NTAPS-1 samples accepted before it. The delay line moves only when `in_valid` is high.
- R2: Tap weights are 16-bit two's complement, and 16384 means a gain of one. The output is the full-precision sum of weight(i)·sample(n−i). It is rounded by adding 8192 and shifting right arithmetically by 14. It is then saturated to the range −8192 to 8191.
- R3: After reset, `out_valid` and `out_data` are 0, the controller is in PH_IDLE and every active weight is zero.
- R4: In PH_IDLE a step pulse has no effect, so every output stays 0.
- R5: A restart in any state loads bank 0 into all taps, selects fundamental state 0 with an increment count of 0, and enters PH_RAMP. A restart overrides a step in the same cycle.
- R6: In PH_RAMP a step adds increment set m to every tap in the same edge, where m is the current fundamental state. The addition wraps modulo 2^16.
- R7: After NSTEPS-1 increments, the next step loads bank m+1 exactly and makes increment set m+1 current. From state NFUND-1 the next state is 0.
- R8: A weight change is atomic at a clock edge. A sample accepted in the same cycle as a step or restart uses the weights from before the change. The next sample uses the new weights.
- R9: A register write (`cfg_we`) stores `cfg_data` at entry [`cfg_state`][`cfg_tap`] of the banks when `cfg_kind`=0, or of the increment sets when `cfg_kind`=1. A write does not alter the active weights until a restart or reload reads that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 12 | Signed input sample |
| adv_i | input | 1 | Interpolation step strobe |
| restart_i | input | 1 | Load bank 0 and begin at fundamental state 0 |
| cfg_we | input | 1 | Register write enable |
| cfg_kind | input | 1 | 0 selects a bank entry, 1 selects an increment entry |
| cfg_state | input | 2 | Fundamental state index of the write |
| cfg_tap | input | 3 | Tap index of the write |
| cfg_data | input | 16 | Signed write value |
| out_valid | output | 1 | Result strobe |
| out_data | output | 14 | Rounded, saturated signed result |

## Verification
Sample acceptance and a weight change can land in the same cycle, and this overlap is where an ordering bug would show. The bench drives `in_valid` together with a step in most cycles of every ramp. It does the same on each reload edge, including the wrap from the last state to state 0, and on a restart edge that also carries a step. Each such sample is judged against weights computed before the change, and the sample that follows is judged against weights computed after it.

// File: rtl/tvfir_pkg.sv
`timescale 1ns/1ps
package tvfir_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RAMP = 2'd1,
        PH_LAST = 2'd2
    } phase_t;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_LOAD0  = 2'd1,
        ACT_ADD    = 2'd2,
        ACT_RELOAD = 2'd3
    } coef_act_t;

endpackage

// File: rtl/tvfir_delay.sv
`timescale 1ns/1ps
module tvfir_delay #(
    parameter int NTAPS = 8,
    parameter int DW    = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  shift_i,
    input  logic [DW-1:0]         din,
    output logic [NTAPS*DW-1:0]   taps_flat
);

    localparam int NHIST = NTAPS - 1;

    logic [DW-1:0] hist_q [NHIST];

    // The newest sample feeds tap 0 directly; older ones come from the line.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NHIST; i++) begin
                hist_q[i] <= '0;
            end
        end else if (shift_i) begin
            hist_q[0] <= din;
            for (int i = 1; i < NHIST; i++) begin
                hist_q[i] <= hist_q[i-1];
            end
        end
    end

    assign taps_flat[DW-1:0] = din;

    for (genvar g = 1; g < NTAPS; g++) begin : g_tap
        assign taps_flat[g*DW +: DW] = hist_q[g-1];
    end

endmodule

// File: rtl/tvfir_mac.sv
`timescale 1ns/1ps
module tvfir_mac #(
    parameter int NTAPS = 8,
    parameter int DW    = 12,
    parameter int CW    = 16,
    parameter int FRAC  = 14,
    parameter int OW    = 14
) (
    input  logic [NTAPS*DW-1:0] taps_flat,
    input  logic [NTAPS*CW-1:0] coef_flat,
    output logic [OW-1:0]       result
);

    localparam int PW = DW + CW;
    localparam int AW = PW + $clog2(NTAPS) + 1;
    localparam logic signed [AW-1:0] HALF = {{(AW-1){1'b0}}, 1'b1} << (FRAC-1);
    localparam logic signed [AW-1:0] OMAX = {{(AW-OW+1){1'b0}}, {(OW-1){1'b1}}};
    localparam logic signed [AW-1:0] OMIN = {{(AW-OW+1){1'b1}}, {(OW-1){1'b0}}};

    logic signed [PW-1:0] prod [NTAPS];
    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] rnd;
    logic signed [AW-1:0] scaled;

    for (genvar g = 0; g < NTAPS; g++) begin : g_mul
        assign prod[g] = $signed(taps_flat[g*DW +: DW]) * $signed(coef_flat[g*CW +: CW]);
    end

    always_comb begin
        acc = '0;
        for (int i = 0; i < NTAPS; i++) begin
            acc = acc + AW'(prod[i]);
        end
        rnd    = acc + HALF;
        scaled = rnd >>> FRAC;
        if (scaled > OMAX) begin
            result = OMAX[OW-1:0];
        end else if (scaled < OMIN) begin
            result = OMIN[OW-1:0];
        end else begin
            result = scaled[OW-1:0];
        end
    end

endmodule

// File: rtl/tvfir_coef.sv
`timescale 1ns/1ps
module tvfir_coef
    import tvfir_pkg::*;
#(
    parameter int NTAPS  = 8,
    parameter int CW     = 16,
    parameter int NFUND  = 4,
    parameter int NSTEPS = 50
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       adv_i,
    input  logic                       restart_i,
    input  logic                       cfg_we,
    input  logic                       cfg_kind,
    input  logic [$clog2(NFUND)-1:0]   cfg_state,
    input  logic [$clog2(NTAPS)-1:0]   cfg_tap,
    input  logic [CW-1:0]              cfg_data,
    output logic [NTAPS*CW-1:0]        coef_flat
);

    localparam int SW   = $clog2(NFUND);
    localparam int CNTW = $clog2(NSTEPS);
    localparam logic [CNTW-1:0] LAST_ADD = CNTW'(NSTEPS - 2);

    logic [CW-1:0]   bank_q  [NFUND][NTAPS];
    logic [CW-1:0]   delta_q [NFUND][NTAPS];
    logic [CW-1:0]   coef_q  [NTAPS];
    phase_t          phase_q, phase_d;
    coef_act_t       act;
    logic [CNTW-1:0] cnt_q;
    logic [SW-1:0]   fund_q;
    logic [SW-1:0]   fund_nx;

    // Register file for banks and increment sets
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NFUND; s++) begin
                for (int t = 0; t < NTAPS; t++) begin
                    bank_q[s][t]  <= '0;
                    delta_q[s][t] <= '0;
                end
            end
        end else if (cfg_we) begin
            if (cfg_kind) begin
                delta_q[cfg_state][cfg_tap] <= cfg_data;
            end else begin
                bank_q[cfg_state][cfg_tap] <= cfg_data;
            end
        end
    end

    assign fund_nx = (fund_q == SW'(NFUND - 1)) ? '0 : fund_q + 1'b1;

    // Next-state and action decode
    always_comb begin
        phase_d = phase_q;
        act     = ACT_NONE;
        unique case (phase_q)
            PH_IDLE: begin
                if (restart_i) begin
                    phase_d = PH_RAMP;
                    act     = ACT_LOAD0;
                end
            end
            PH_RAMP: begin
                if (restart_i) begin
                    act = ACT_LOAD0;
                end else if (adv_i) begin
                    act = ACT_ADD;
                    if (cnt_q == LAST_ADD) begin
                        phase_d = PH_LAST;
                    end
                end
            end
            PH_LAST: begin
                if (restart_i) begin
                    phase_d = PH_RAMP;
                    act     = ACT_LOAD0;
                end else if (adv_i) begin
                    phase_d = PH_RAMP;
                    act     = ACT_RELOAD;
                end
            end
            default: begin
                phase_d = PH_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Active weights, step counter and fundamental index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            fund_q <= '0;
            for (int t = 0; t < NTAPS; t++) begin
                coef_q[t] <= '0;
            end
        end else begin
            unique case (act)
                ACT_LOAD0: begin
                    cnt_q  <= '0;
                    fund_q <= '0;
                    for (int t = 0; t < NTAPS; t++) begin
                        coef_q[t] <= bank_q[0][t];
                    end
                end
                ACT_ADD: begin
                    cnt_q <= cnt_q + 1'b1;
                    for (int t = 0; t < NTAPS; t++) begin
                        coef_q[t] <= coef_q[t] + delta_q[fund_q][t];
                    end
                end
                ACT_RELOAD: begin
                    cnt_q  <= '0;
                    fund_q <= fund_nx;
                    for (int t = 0; t < NTAPS; t++) begin
                        coef_q[t] <= bank_q[fund_nx][t];
                    end
                end
                default: begin
                end
            endcase
        end
    end

    for (genvar g = 0; g < NTAPS; g++) begin : g_out
        assign coef_flat[g*CW +: CW] = coef_q[g];
    end

    // R5: a restart always lands in RAMP at state 0, count 0
    a_r5_restart_lands: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (phase_q == PH_RAMP && fund_q == '0 && cnt_q == '0));

    // R7: the final phase is reached only after the full increment count
    a_r7_last_count: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_LAST) |-> (cnt_q == CNTW'(NSTEPS - 1)));

    // R7: the reload advances the fundamental index and wraps after the last
    a_r7_fund_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_LAST && adv_i && !restart_i) |=>
        (fund_q == (($past(fund_q) == SW'(NFUND - 1)) ? SW'(0) : SW'($past(fund_q) + 1'b1))));

    // R4: weights stay frozen in IDLE whatever the step strobe does
    a_r4_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE && !restart_i) |=> $stable(coef_flat));

endmodule

// File: rtl/tvfir_interp.sv
`timescale 1ns/1ps
module tvfir_interp #(
    parameter int NTAPS  = 8,
    parameter int DW     = 12,
    parameter int CW     = 16,
    parameter int FRAC   = 14,
    parameter int OW     = 14,
    parameter int NFUND  = 4,
    parameter int NSTEPS = 50
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [DW-1:0]              in_data,
    input  logic                       adv_i,
    input  logic                       restart_i,
    input  logic                       cfg_we,
    input  logic                       cfg_kind,
    input  logic [$clog2(NFUND)-1:0]   cfg_state,
    input  logic [$clog2(NTAPS)-1:0]   cfg_tap,
    input  logic [CW-1:0]              cfg_data,
    output logic                       out_valid,
    output logic [OW-1:0]              out_data
);

    logic [NTAPS*DW-1:0] taps_flat;
    logic [NTAPS*CW-1:0] coef_flat;
    logic [OW-1:0]       mac_result;

    tvfir_delay #(.NTAPS(NTAPS), .DW(DW)) u_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_i   (in_valid),
        .din       (in_data),
        .taps_flat (taps_flat)
    );

    tvfir_coef #(.NTAPS(NTAPS), .CW(CW), .NFUND(NFUND), .NSTEPS(NSTEPS)) u_coef (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv_i     (adv_i),
        .restart_i (restart_i),
        .cfg_we    (cfg_we),
        .cfg_kind  (cfg_kind),
        .cfg_state (cfg_state),
        .cfg_tap   (cfg_tap),
        .cfg_data  (cfg_data),
        .coef_flat (coef_flat)
    );

    tvfir_mac #(.NTAPS(NTAPS), .DW(DW), .CW(CW), .FRAC(FRAC), .OW(OW)) u_mac (
        .taps_flat (taps_flat),
        .coef_flat (coef_flat),
        .result    (mac_result)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= mac_result;
            end
        end
    end

    // R1: one result per accepted sample, one cycle later
    a_r1_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1: no result without an accepted sample
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

endmodule

// File: tb/tvfir_interp_test.sv
`timescale 1ns/1ps
module tvfir_interp_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] in_data = '0;
    logic        adv_i = 1'b0;
    logic        restart_i = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_kind = 1'b0;
    logic [1:0]  cfg_state = '0;
    logic [2:0]  cfg_tap = '0;
    logic [15:0] cfg_data = '0;
    logic        out_valid;
    logic [13:0] out_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Bench model of the requirements
    int bk [4][8];
    int dl [4][8];
    int cf [8];
    int hs [8];
    int phase = 0;
    int fund = 0;
    int cnt = 0;

    int    exp_q [$];
    string tag_q [$];

    tvfir_interp uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .adv_i(adv_i), .restart_i(restart_i), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_state(cfg_state), .cfg_tap(cfg_tap), .cfg_data(cfg_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #2.5 clk = ~clk;

    function automatic int w16(int v);
        logic signed [15:0] t;
        t = v[15:0];
        return int'(t);
    endfunction

    function automatic int expect_out();
        longint acc = 0;
        longint r;
        for (int i = 0; i < 8; i++) acc += longint'(cf[i]) * longint'(hs[i]);
        r = (acc + 64'sd8192) >>> 14;
        if (r > 8191) r = 8191;
        if (r < -8192) r = -8192;
        return int'(r);
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus, expected result pushed to the scoreboard
    task automatic drive(bit v, int x, bit adv_b, bit rs, string tag);
        @(negedge clk);
        cfg_we = 1'b0; in_valid = v; in_data = 12'(x); adv_i = adv_b; restart_i = rs;
        if (v) begin
            for (int i = 7; i > 0; i--) hs[i] = hs[i-1];
            hs[0] = x;
            exp_q.push_back(expect_out());
            tag_q.push_back(tag);
        end
        if (rs) begin
            for (int t = 0; t < 8; t++) cf[t] = bk[0][t];
            phase = 1; fund = 0; cnt = 0;
        end else if (adv_b && phase == 1) begin
            for (int t = 0; t < 8; t++) cf[t] = w16(cf[t] + dl[fund][t]);
            cnt++;
            if (cnt == 49) phase = 2;
        end else if (adv_b && phase == 2) begin
            fund = (fund + 1) % 4;
            for (int t = 0; t < 8; t++) cf[t] = bk[fund][t];
            cnt = 0; phase = 1;
        end
    endtask

    task automatic cfg(bit kind, int st, int tap, int val);
        @(negedge clk);
        in_valid = 1'b0; adv_i = 1'b0; restart_i = 1'b0;
        cfg_we = 1'b1; cfg_kind = kind; cfg_state = 2'(st); cfg_tap = 3'(tap); cfg_data = 16'(val);
        if (kind) dl[st][tap] = w16(val);
        else bk[st][tap] = w16(val);
    endtask

    // Monitor: compare each produced result with the oldest expectation
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R1 actual=unexpected_output expected=none");
            end else begin
                check(tag_q.pop_front(), int'($signed(out_data)), exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 4; s++)
            for (int t = 0; t < 8; t++) begin bk[s][t] = 0; dl[s][t] = 0; end
        for (int t = 0; t < 8; t++) begin cf[t] = 0; hs[t] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 out_valid", int'(out_valid), 0);
        check("R3 out_data", int'(out_data), 0);

        // R3/R4: idle weights are zero and steps do nothing
        drive(1, 700, 1, 0, "R3");
        drive(1, -900, 1, 0, "R4");
        drive(1, 2047, 1, 0, "R4");
        drive(0, 0, 1, 0, "R4");
        drive(1, -2048, 0, 0, "R4");

        // R9: load banks and increment sets
        for (int s = 0; s < 4; s++)
            for (int t = 0; t < 8; t++) begin
                if (s == 2) cfg(0, s, t, 32767);
                else cfg(0, s, t, ((s + 1) * 2900 * ((t % 3) - 1)) + 16384 * (t == s ? 1 : 0));
                cfg(1, s, t, (t - 3) * 23 * (s + 1) - s * 5);
            end

        // R8: restart with a sample in the same cycle uses zero weights
        drive(1, 500, 0, 1, "R8");
        drive(1, 1, 0, 0, "R8");
        // R1/R2: assorted patterns with gaps
        drive(1, 2047, 0, 0, "R2");
        drive(0, 0, 0, 0, "R1");
        drive(1, -2048, 0, 0, "R2");
        drive(1, -7, 0, 0, "R2");
        drive(0, 0, 0, 0, "R1");
        drive(0, 0, 0, 0, "R1");
        drive(1, 1234, 0, 0, "R1");
        drive(1, 1, 0, 0, "R2");
        drive(1, -1, 0, 0, "R2");

        // R9: write during ramp changes nothing until reload reads it
        cfg(0, 1, 0, -12345);
        drive(1, 333, 0, 0, "R9");
        drive(1, -444, 0, 0, "R9");

        // R6/R7/R8: run through all four states and the wrap to state 0
        for (int k = 0; k < 215; k++) begin
            int x;
            string tg;
            if (fund == 2 && cnt < 8) x = 2047;
            else if (fund == 2 && cnt < 16) x = -2048;
            else x = ((k * 397) % 4001) - 2000;
            if (phase == 2) tg = "R7";
            else if (fund == 2 && cnt < 16) tg = "R2";
            else tg = "R6";
            drive(1, x, 1, 0, tg);
            if (k % 9 == 0) drive(1, -x / 2, 0, 0, "R8");
        end

        // R5: restart overrides a step in the same cycle
        drive(1, 1500, 1, 1, "R5");
        drive(1, -1500, 0, 0, "R5");
        drive(1, 77, 1, 0, "R5");
        drive(1, 900, 0, 0, "R5");

        drive(0, 0, 0, 0, "R1");
        drive(0, 0, 0, 0, "R1");
        @(negedge clk);
        check("R1 pending", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule